// File: doc/BRIEF.md
# Prioritised Interrupt Controller

This block gathers every interrupt request of a processor subsystem into one prioritised request for the CPU. The sources are a non-maskable input, eight external request pins, a group of eight pin-change lines and a set of on-chip peripheral request lines. Detection turns each input into a pending bit. An arbiter then picks the winner among the pending sources and compares its level with the CPU's current mask. The block presents the winner as a request with a level and a vector number.

Each maskable source has a 4-bit priority set through a small write port. Level 0 turns a source off. The non-maskable input sits above all sixteen programmable levels. When the CPU accepts the request, it pulses acknowledge. The block then clears the edge-latched pending state of the accepted source. In the next cycle it raises a one-cycle request telling the CPU to switch to its shadow register bank.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, req_o, bank_save_o and pin_pend_o are all zero. All priorities are 0 and all request pins are in low-level mode.
- R2: A rising edge on nmi_i creates a pending request. That request is always presented with level_o = 16 and vector_o = NMI_VEC (default 11), whatever the mask, and it is cleared by acknowledge.
- R3: A maskable source is presented only if its level is strictly greater than mask_i. A source with priority 0 is never presented.
- R4: Among pending maskable sources the highest level wins. On equal levels the lowest source index wins. The source indices are: request pins 0..7, the pin-change group 8, peripheral j at 9+j.
- R5: For a maskable winner, vector_o = VEC_BASE + source index (default VEC_BASE = 64). level_o carries the winner's 4-bit priority, zero-extended to 5 bits.
- R6: Writing wr_data_i[1:0] to address 24+k sets the detection mode of request pin k: 0 = low level, 1 = falling edge, 2 = rising edge, 3 = both edges. Writing wr_data_i[3:0] to address i (i < 9+N_PER) sets the priority of source i.
- R7: In an edge mode, acknowledge clears the pin's pending bit. In low-level mode the request stays pending as long as the pin is low, and acknowledge has no effect on it.
- R8: Each pin-change line latches a falling edge into its own bit of pin_pend_o. The group shares the priority at address 8 and vector index 8. Acknowledging the group clears all of its bits.
- R9: bank_save_o is high for exactly the cycle after an acknowledge that met a presented request. An acknowledge while req_o is low leaves it low.
- R10: Peripheral request lines are level sensitive, with no latch. Peripheral j's priority sits at address 9+j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nmi_i | input | 1 | Non-maskable request, rising edge |
| irq_i | input | N_IRQ | External request pins, idle high |
| pin_i | input | N_PIN | Pin-change lines, idle high |
| per_req_i | input | N_PER | Peripheral request lines, active high |
| mask_i | input | 4 | CPU interrupt mask level |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_addr_i | input | 5 | Configuration address |
| wr_data_i | input | 4 | Configuration data |
| ack_i | input | 1 | CPU accepts the presented request |
| req_o | output | 1 | Request to CPU |
| level_o | output | 5 | Level of presented request (16 = NMI) |
| vector_o | output | 8 | Vector number of presented request |
| bank_save_o | output | 1 | Register-bank save request |
| pin_pend_o | output | N_PIN | Pending bits of the pin-change group |

## Verification
The bench uses the default build: eight request pins, eight pin-change lines, four peripheral lines, vector base 64 and NMI vector 11. With four peripherals, two of them can share a level, so the index tie-break is reachable through peripherals alone. Every mask boundary can also be swept combinationally from a table. All four detection modes, both group clears and the NMI override are exercised on the fixed pins.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int unsigned PRIO_W  = 4;
  localparam int unsigned MODE_W  = 2;
  localparam int unsigned ADDR_W  = 5;
  localparam int unsigned MODE_BASE = 24;

  typedef enum logic [MODE_W-1:0] {
    DET_LOW  = 2'd0,
    DET_FALL = 2'd1,
    DET_RISE = 2'd2,
    DET_BOTH = 2'd3
  } det_mode_e;
endpackage

// File: rtl/prio_irq_det.sv
module prio_irq_det
  import prio_irq_pkg::*;
#(
  parameter logic IDLE = 1'b1
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      pin_i,
  input  det_mode_e mode_i,
  input  logic      clr_i,
  output logic      pend_o
);
  logic smp_q, prv_q, lat_q, hit;

  always_comb begin
    unique case (mode_i)
      DET_FALL: hit = prv_q & ~smp_q;
      DET_RISE: hit = ~prv_q & smp_q;
      DET_BOTH: hit = prv_q ^ smp_q;
      default:  hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q <= IDLE;
      prv_q <= IDLE;
      lat_q <= 1'b0;
    end else begin
      smp_q <= pin_i;
      prv_q <= smp_q;
      // a new edge wins over a simultaneous clear
      lat_q <= (mode_i != DET_LOW) & (hit | (lat_q & ~clr_i));
    end
  end

  assign pend_o = (mode_i == DET_LOW) ? ~smp_q : lat_q;

  p_edge_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !hit && mode_i != DET_LOW) |=> (!pend_o || mode_i == DET_LOW));
endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb
  import prio_irq_pkg::*;
#(
  parameter int unsigned N_SRC = 13,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0][PRIO_W-1:0] lvl_i,
  input  logic [PRIO_W-1:0]            mask_i,
  output logic                         hit_o,
  output logic [IDX_W-1:0]             idx_o,
  output logic [PRIO_W-1:0]            lvl_o
);
  always_comb begin
    lvl_o = '0;
    idx_o = '0;
    for (int i = 0; i < N_SRC; i++) begin
      // strict compare keeps the lowest index on ties
      if (lvl_i[i] > lvl_o) begin
        lvl_o = lvl_i[i];
        idx_o = IDX_W'(i);
      end
    end
    hit_o = lvl_o > mask_i;
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int unsigned N_IRQ    = 8,
  parameter int unsigned N_PIN    = 8,
  parameter int unsigned N_PER    = 4,
  parameter logic [7:0]  VEC_BASE = 8'd64,
  parameter logic [7:0]  NMI_VEC  = 8'd11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              nmi_i,
  input  logic [N_IRQ-1:0]  irq_i,
  input  logic [N_PIN-1:0]  pin_i,
  input  logic [N_PER-1:0]  per_req_i,
  input  logic [3:0]        mask_i,
  input  logic              wr_en_i,
  input  logic [4:0]        wr_addr_i,
  input  logic [3:0]        wr_data_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic [4:0]        level_o,
  output logic [7:0]        vector_o,
  output logic              bank_save_o,
  output logic [N_PIN-1:0]  pin_pend_o
);
  localparam int unsigned PIN_IDX = N_IRQ;
  localparam int unsigned PER_IDX = N_IRQ + 1;
  localparam int unsigned N_SRC   = N_IRQ + 1 + N_PER;
  localparam int unsigned IDX_W   = $clog2(N_SRC);

  logic [N_SRC-1:0][PRIO_W-1:0] prio_q;
  det_mode_e [N_IRQ-1:0]        mode_q;
  logic [N_SRC-1:0]             src_pend;
  logic [N_SRC-1:0][PRIO_W-1:0] eff_lvl;
  logic [N_IRQ-1:0]             irq_pend, irq_clr;
  logic                         nmi_pend, nmi_clr, pin_clr;
  logic                         hit;
  logic [IDX_W-1:0]             win_idx;
  logic [PRIO_W-1:0]            win_lvl;
  logic                         take;

  // configuration registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_q <= '0;
      mode_q <= {N_IRQ{DET_LOW}};
    end else if (wr_en_i) begin
      for (int i = 0; i < N_SRC; i++)
        if (wr_addr_i == ADDR_W'(i)) prio_q[i] <= wr_data_i;
      for (int k = 0; k < N_IRQ; k++)
        if (wr_addr_i == ADDR_W'(MODE_BASE + k)) mode_q[k] <= det_mode_e'(wr_data_i[1:0]);
    end
  end

  // detection
  prio_irq_det #(.IDLE(1'b0)) u_nmi (
    .clk_i, .rst_ni, .pin_i(nmi_i), .mode_i(DET_RISE), .clr_i(nmi_clr), .pend_o(nmi_pend)
  );

  for (genvar k = 0; k < N_IRQ; k++) begin : g_irq
    prio_irq_det #(.IDLE(1'b1)) u_det (
      .clk_i, .rst_ni, .pin_i(irq_i[k]), .mode_i(mode_q[k]),
      .clr_i(irq_clr[k]), .pend_o(irq_pend[k])
    );
    assign irq_clr[k] = take & ~nmi_pend & (win_idx == IDX_W'(k));
  end

  for (genvar p = 0; p < N_PIN; p++) begin : g_pin
    prio_irq_det #(.IDLE(1'b1)) u_det (
      .clk_i, .rst_ni, .pin_i(pin_i[p]), .mode_i(DET_FALL),
      .clr_i(pin_clr), .pend_o(pin_pend_o[p])
    );
  end

  assign src_pend = {per_req_i, |pin_pend_o, irq_pend};

  for (genvar i = 0; i < N_SRC; i++) begin : g_eff
    assign eff_lvl[i] = src_pend[i] ? prio_q[i] : '0;
  end

  prio_irq_arb #(.N_SRC(N_SRC)) u_arb (
    .lvl_i(eff_lvl), .mask_i, .hit_o(hit), .idx_o(win_idx), .lvl_o(win_lvl)
  );

  assign req_o    = nmi_pend | hit;
  assign level_o  = nmi_pend ? 5'd16 : {1'b0, win_lvl};
  assign vector_o = nmi_pend ? NMI_VEC : VEC_BASE + 8'(win_idx);

  assign take    = ack_i & req_o;
  assign nmi_clr = take & nmi_pend;
  assign pin_clr = take & ~nmi_pend & (win_idx == IDX_W'(PIN_IDX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bank_save_o <= 1'b0;
    else         bank_save_o <= take;
  end

  p_nmi_top_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_pend |-> (req_o && level_o == 5'd16 && vector_o == NMI_VEC));
  p_mask_strict_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && level_o != 5'd16) |-> (level_o[3:0] > mask_i));
  p_no_zero_lvl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> level_o != 5'd0);
  p_bank_after_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_save_o |-> $past(req_o));
  p_pin_cleared_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_clr && $stable(pin_i)) |=> ($countones(pin_pend_o) <= $countones(~$past(pin_i))));
  initial assert (PER_IDX + N_PER <= MODE_BASE);
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic nmi = 1'b0, ack = 1'b0, wr_en = 1'b0;
  logic [7:0] irq = '1, pin = '1;
  logic [3:0] per = '0, mask = '0, wr_data = '0;
  logic [4:0] wr_addr = '0;
  logic req, bank;
  logic [4:0] lvl;
  logic [7:0] vec, pend;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  prio_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .nmi_i(nmi), .irq_i(irq), .pin_i(pin),
    .per_req_i(per), .mask_i(mask), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .ack_i(ack), .req_o(req), .level_o(lvl),
    .vector_o(vec), .bank_save_o(bank), .pin_pend_o(pend)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic see(input string tag, input int r, input int l, input int v);
    chk({tag, " req"}, int'(req), r);
    if (r != 0) begin
      chk({tag, " level"}, int'(lvl), l);
      chk({tag, " vector"}, int'(vec), v);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1'b1; wr_addr = 5'(a); wr_data = 4'(d);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  // mask, per, req, level, vector
  localparam logic [21:0] TBL [10] = '{
    {4'd0,  4'b0000, 1'b0, 5'd0,  8'd0},
    {4'd0,  4'b0001, 1'b1, 5'd3,  8'd73},
    {4'd3,  4'b0001, 1'b0, 5'd0,  8'd0},
    {4'd2,  4'b0001, 1'b1, 5'd3,  8'd73},
    {4'd0,  4'b0110, 1'b1, 5'd7,  8'd74},
    {4'd6,  4'b0111, 1'b1, 5'd7,  8'd74},
    {4'd11, 4'b1111, 1'b1, 5'd12, 8'd76},
    {4'd12, 4'b1111, 1'b0, 5'd0,  8'd0},
    {4'd0,  4'b0100, 1'b1, 5'd7,  8'd75},
    {4'd7,  4'b0110, 1'b0, 5'd0,  8'd0}
  };

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_n(3); rst_n = 1'b1; wait_n(2);
    // R1 reset state
    chk("R1 req", int'(req), 0);
    chk("R1 bank", int'(bank), 0);
    chk("R1 pin_pend", int'(pend), 0);
    per = 4'b1111; @(negedge clk);
    chk("R1 prio zero", int'(req), 0);
    per = '0;

    // R10 peripheral priorities, R3/R4/R5 table
    wr(9, 3); wr(10, 7); wr(11, 7); wr(12, 12);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      mask = TBL[i][21:18]; per = TBL[i][17:14];
      @(negedge clk);
      see($sformatf("R4 R10 row%0d", i), int'(TBL[i][13]), int'(TBL[i][12:8]), int'(TBL[i][7:0]));
    end
    per = '0; mask = '0;
    wr(9, 0); per = 4'b0001; @(negedge clk);
    chk("R3 prio0 disables", int'(req), 0);
    per = '0;

    // R6/R7 falling edge on irq3
    wr(3, 9); wr(24 + 3, 1);
    irq[3] = 1'b0; wait_n(3);
    see("R6 fall irq3", 1, 9, 67);
    do_ack();
    chk("R9 bank pulse", int'(bank), 1);
    chk("R7 edge cleared", int'(req), 0);
    @(negedge clk);
    chk("R9 bank one cycle", int'(bank), 0);
    irq[3] = 1'b1; wait_n(3);
    chk("R6 fall ignores rise", int'(req), 0);

    // R7 level mode not cleared by ack
    wr(4, 5);
    irq[4] = 1'b0; wait_n(3);
    see("R6 low irq4", 1, 5, 68);
    do_ack();
    chk("R7 level persists", int'(req), 1);
    irq[4] = 1'b1; wait_n(3);
    chk("R7 level released", int'(req), 0);

    // R6 rising and both
    wr(5, 6); wr(24 + 5, 2);
    irq[5] = 1'b0; wait_n(3);
    chk("R6 rise ignores fall", int'(req), 0);
    irq[5] = 1'b1; wait_n(3);
    see("R6 rise irq5", 1, 6, 69);
    do_ack();
    wr(6, 6); wr(24 + 6, 3);
    irq[6] = 1'b0; wait_n(3);
    see("R6 both fall irq6", 1, 6, 70);
    do_ack();
    chk("R7 both cleared", int'(req), 0);
    irq[6] = 1'b1; wait_n(3);
    see("R6 both rise irq6", 1, 6, 70);
    do_ack();

    // R4 tie between irq1 and irq2
    wr(1, 8); wr(2, 8); wr(24 + 1, 1); wr(24 + 2, 1);
    irq[1] = 1'b0; irq[2] = 1'b0; wait_n(3);
    see("R4 tie low index", 1, 8, 65);
    do_ack();
    see("R4 tie next", 1, 8, 66);
    do_ack();
    chk("R4 tie drained", int'(req), 0);
    irq[1] = 1'b1; irq[2] = 1'b1; wait_n(3);

    // R9 ack with nothing presented
    do_ack();
    chk("R9 no bank without req", int'(bank), 0);

    // R2 NMI over mask
    mask = 4'd15; per = 4'b1000;
    nmi = 1'b1; wait_n(3);
    see("R2 nmi", 1, 16, 11);
    do_ack();
    chk("R2 nmi cleared", int'(req), 0);
    nmi = 1'b0; per = '0; mask = '0;

    // R8 pin group
    wr(8, 4);
    pin[2] = 1'b0; pin[5] = 1'b0; wait_n(3);
    chk("R8 pin pending", int'(pend), 8'h24);
    see("R8 pin group", 1, 4, 72);
    do_ack();
    chk("R8 pin cleared", int'(pend), 0);
    chk("R8 pin req gone", int'(req), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule